// File: doc/BRIEF.md
# 64B/66B Receive Block Classifier

This block sits after block lock and descrambling on the receive side of a 64B/66B physical coding sublayer. Each cycle with `in_valid` high it accepts one 66-bit block. Bits [1:0] hold the two-bit sync header and bits [65:2] hold the 64-bit payload. Payload octet n occupies payload bits [8n+7:8n]. In a control block, payload octet 0 is the block type field.

One cycle later it reports the following:
- the kind of block: data, control or errored;
- framing events: a frame start and its lane, and a terminate and its position;
- ordered sets, with their code class, their three payload octets and a fault decode;
- the error-character condition;
- exactly one error cause when the block is malformed.

A link monitor (a two-state machine with states BER_OK and BER_HIGH) counts invalid sync headers over a window of valid blocks and raises `hi_ber` when the count reaches a threshold. It has three transitions:
- BER_OK to BER_HIGH ("trip"): the count reaches the threshold.
- BER_HIGH to BER_OK ("recover"): a window closes with a count below the threshold.
- BER_HIGH stays in BER_HIGH ("hold"): any other cycle.

The block is meant for line monitors and capture triggers that need the cause of every bad block rather than a rebuilt lane stream.

Top module: `pcs_blk_classifier`

## Requirements
- R1: Sync header `2'b01` gives kind data (`out_kind`=0), `2'b10` gives control (`out_kind`=1), and `2'b00` or `2'b11` gives errored (`out_kind`=2) with `out_err_hdr`=1 and no other flag.
- R2: A control block whose type field is outside {0x1e, 0x2d, 0x33, 0x4b, 0x55, 0x66, 0x78, 0x87, 0x99, 0xaa, 0xb4, 0xcc, 0xd2, 0xe1, 0xff} sets `out_err_type` and kind errored.
- R3: `out_err_code` is set, with kind errored, in three cases: a 7-bit control code outside {0x00, 0x1e, 0x2d, 0x33, 0x4b, 0x55, 0x66, 0x78}; a 4-bit ordered-set code other than 0x0 or 0xf; or a nonzero reserved bit inside a control block.
- R4: A 7-bit code 0x1e in any control position sets `out_err_char`, and the kind is errored.
- R5: Type 0x78 reports a frame start in lane 0 (`out_sof`=1, `out_sof_lane4`=0). Types 0x33 and 0x66 report a frame start in lane 4 (`out_sof_lane4`=1).
- R6: Types 0x87, 0x99, 0xaa, 0xb4, 0xcc, 0xd2, 0xe1 and 0xff set `out_term` with `out_term_pos` 0 through 7 in that order.
- R7: Types 0x4b, 0x55 and 0x66 report the lane-0 ordered set (code in payload bits [35:32], octets in payload [31:8]). Type 0x2d reports the lane-4 ordered set (code in [39:36], octets in [63:40]). `out_oset_sig`=1 when the code is 0xf, and `out_oset_data[7:0]` holds the first octet.
- R8: A sequence ordered set (code 0x0) with octets 0x00, 0x00, 0x01 sets `out_local_fault`. With octets 0x00, 0x00, 0x02 it sets `out_remote_fault`.
- R9: Frame, ordered-set and fault flags appear only for clean control blocks. Error causes are exclusive, with priority header over type over code.
- R10: Outputs are registered. `out_valid` follows `in_valid` by one cycle, and reset clears every output.
- R11: `hi_ber` rises on the cycle after the valid block that brings the count of bad headers in the current window to BER_THRESH.
- R12: When a window of WIN_BLOCKS valid blocks closes, `hi_ber` is cleared if that window held fewer than BER_THRESH bad headers, and is held otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A block is presented this cycle |
| in_block | input | 66 | Descrambled block, sync header in [1:0] |
| out_valid | output | 1 | Classification outputs are fresh |
| out_kind | output | 2 | 0 data, 1 control, 2 errored |
| out_sof | output | 1 | Frame start in this block |
| out_sof_lane4 | output | 1 | Frame start is in lane 4 |
| out_term | output | 1 | Terminate in this block |
| out_term_pos | output | 3 | Terminate position 0..7 |
| out_oset | output | 1 | Ordered set present |
| out_oset_sig | output | 1 | Ordered set is the signal class |
| out_oset_data | output | 24 | Ordered-set octets, first in [7:0] |
| out_local_fault | output | 1 | Local fault sequence seen |
| out_remote_fault | output | 1 | Remote fault sequence seen |
| out_err_char | output | 1 | Error control character seen |
| out_err_hdr | output | 1 | Invalid sync header |
| out_err_type | output | 1 | Unknown block type |
| out_err_code | output | 1 | Bad control code, ordered-set code or reserved bit |
| hi_ber | output | 1 | High error rate on sync headers |

## Verification
The bench sweeps all 256 type fields under a control header and all 128 7-bit codes in the first slot of an all-control block. It also sweeps the four sync headers. A decoder with a wrong entry in the type list would therefore misreport a legal type as errored, and a wrong terminate mapping would give a shifted position. Directed blocks place nonzero reserved bits, bad ordered-set codes and error characters beside terminates and frame starts. A design that let framing flags through on an errored block, or that reported two causes at once, would be caught there. The rate monitor runs with a window of 8 and a threshold of 3. The bench checks the exact block on which `hi_ber` trips, that it holds across a window that reached the threshold, and that it clears at the first quiet window end and not one block early.

// File: rtl/pcs_cls_pkg.sv
package pcs_cls_pkg;

    typedef enum logic [1:0] {
        KIND_DATA = 2'd0,
        KIND_CTRL = 2'd1,
        KIND_ERR  = 2'd2
    } blk_kind_e;

    localparam logic [1:0] SH_DATA = 2'b01;
    localparam logic [1:0] SH_CTRL = 2'b10;

    function automatic logic code7_legal(input logic [6:0] c);
        return c inside {7'h00, 7'h1e, 7'h2d, 7'h33, 7'h4b, 7'h55, 7'h66, 7'h78};
    endfunction

    // Returns {any illegal code, any error code} over n 7-bit slots from bit lo.
    function automatic logic [1:0] scan_codes(input logic [63:0] p, input int lo, input int n);
        logic       bad;
        logic       ec;
        logic [6:0] c;
        bad = 1'b0;
        ec  = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < n) begin
                c = 7'(p >> (lo + 7 * i));
                if (!code7_legal(c)) bad = 1'b1;
                if (c == 7'h1e)      ec  = 1'b1;
            end
        end
        return {bad, ec};
    endfunction

    function automatic logic rsv_nonzero(input logic [63:0] p, input int lo, input int n);
        logic [63:0] m;
        m = (n == 0) ? 64'd0 : ((64'd1 << n) - 64'd1);
        return ((p >> lo) & m) != 64'd0;
    endfunction

    function automatic logic ocode_bad(input logic [3:0] o);
        return !(o == 4'h0 || o == 4'hf);
    endfunction

endpackage

// File: rtl/pcs_ctrl_decode.sv
module pcs_ctrl_decode
    import pcs_cls_pkg::*;
(
    input  logic [63:0] payload,
    output logic        type_ok,
    output logic        code_bad,
    output logic        err_char,
    output logic        sof,
    output logic        sof_lane4,
    output logic        term,
    output logic [2:0]  term_pos,
    output logic        oset,
    output logic        oset_sig,
    output logic [23:0] oset_data
);
    logic [7:0] tf;
    logic [3:0] ocode;
    logic [1:0] sc;
    int         tp;

    assign tf = payload[7:0];

    always_comb begin
        type_ok   = 1'b1;
        code_bad  = 1'b0;
        err_char  = 1'b0;
        sof       = 1'b0;
        sof_lane4 = 1'b0;
        term      = 1'b0;
        term_pos  = 3'd0;
        oset      = 1'b0;
        ocode     = 4'h0;
        oset_data = 24'h0;
        sc        = 2'b00;
        tp        = 0;
        case (tf)
            8'h1e: sc = scan_codes(payload, 8, 8);
            8'h2d: begin
                sc        = scan_codes(payload, 8, 4);
                oset      = 1'b1;
                ocode     = payload[39:36];
                oset_data = payload[63:40];
                code_bad  = ocode_bad(ocode);
            end
            8'h33: begin
                sc        = scan_codes(payload, 8, 4);
                code_bad  = rsv_nonzero(payload, 36, 4);
                sof       = 1'b1;
                sof_lane4 = 1'b1;
            end
            8'h66: begin
                oset      = 1'b1;
                ocode     = payload[35:32];
                oset_data = payload[31:8];
                code_bad  = ocode_bad(ocode) | rsv_nonzero(payload, 36, 4);
                sof       = 1'b1;
                sof_lane4 = 1'b1;
            end
            8'h55: begin
                oset      = 1'b1;
                ocode     = payload[35:32];
                oset_data = payload[31:8];
                code_bad  = ocode_bad(ocode) | ocode_bad(payload[39:36]);
            end
            8'h78: sof = 1'b1;
            8'h4b: begin
                sc        = scan_codes(payload, 36, 4);
                oset      = 1'b1;
                ocode     = payload[35:32];
                oset_data = payload[31:8];
                code_bad  = ocode_bad(ocode);
            end
            8'h87, 8'h99, 8'haa, 8'hb4, 8'hcc, 8'hd2, 8'he1, 8'hff: begin
                case (tf)
                    8'h87:   tp = 0;
                    8'h99:   tp = 1;
                    8'haa:   tp = 2;
                    8'hb4:   tp = 3;
                    8'hcc:   tp = 4;
                    8'hd2:   tp = 5;
                    8'he1:   tp = 6;
                    default: tp = 7;
                endcase
                term     = 1'b1;
                term_pos = 3'(tp);
                code_bad = rsv_nonzero(payload, 8 + 8 * tp, 7 - tp);
                sc       = scan_codes(payload, 15 + 7 * tp, 7 - tp);
            end
            default: type_ok = 1'b0;
        endcase
        code_bad = code_bad | sc[1];
        err_char = sc[0];
        oset_sig = (ocode == 4'hf);
    end
endmodule

// File: rtl/pcs_ber_fsm.sv
module pcs_ber_fsm #(
    parameter int WIN_BLOCKS = 19531,
    parameter int BER_THRESH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blk_valid,
    input  logic hdr_bad,
    output logic hi_ber
);
    localparam int WIN_W = (WIN_BLOCKS > 1) ? $clog2(WIN_BLOCKS) : 1;
    localparam int CNT_W = $clog2(BER_THRESH + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_BLOCKS - 1);
    localparam logic [CNT_W-1:0] THR      = CNT_W'(BER_THRESH);

    typedef enum logic {BER_OK, BER_HIGH} ber_state_e;

    ber_state_e       state, state_nx;
    logic [WIN_W-1:0] blk_cnt;
    logic [CNT_W-1:0] err_cnt, cnt_nx;
    logic             win_end;

    assign win_end = blk_valid && (blk_cnt == WIN_LAST);
    assign cnt_nx  = (blk_valid && hdr_bad && err_cnt != THR) ? err_cnt + 1'b1 : err_cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            BER_OK:   if (blk_valid && cnt_nx >= THR) state_nx = BER_HIGH;
            BER_HIGH: if (win_end && cnt_nx < THR)    state_nx = BER_OK;
            default:  state_nx = BER_OK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= BER_OK;
            blk_cnt <= '0;
            err_cnt <= '0;
        end else begin
            state <= state_nx;
            if (blk_valid) begin
                if (win_end) begin
                    blk_cnt <= '0;
                    err_cnt <= '0;
                end else begin
                    blk_cnt <= blk_cnt + 1'b1;
                    err_cnt <= cnt_nx;
                end
            end
        end
    end

    always_comb hi_ber = (state == BER_HIGH);
endmodule

// File: rtl/pcs_blk_classifier.sv
module pcs_blk_classifier
    import pcs_cls_pkg::*;
#(
    parameter int WIN_BLOCKS = 19531,
    parameter int BER_THRESH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [65:0] in_block,
    output logic        out_valid,
    output logic [1:0]  out_kind,
    output logic        out_sof,
    output logic        out_sof_lane4,
    output logic        out_term,
    output logic [2:0]  out_term_pos,
    output logic        out_oset,
    output logic        out_oset_sig,
    output logic [23:0] out_oset_data,
    output logic        out_local_fault,
    output logic        out_remote_fault,
    output logic        out_err_char,
    output logic        out_err_hdr,
    output logic        out_err_type,
    output logic        out_err_code,
    output logic        hi_ber
);
    logic [1:0]  sync;
    logic [63:0] payload;
    logic        is_ctl, hdr_bad;
    logic        d_type_ok, d_code_bad, d_err_char, d_sof, d_sof4, d_term, d_oset, d_osig;
    logic [2:0]  d_tpos;
    logic [23:0] d_odata;
    logic        e_type, e_code, e_char, clean;
    blk_kind_e   kind;

    assign sync    = in_block[1:0];
    assign payload = in_block[65:2];
    assign is_ctl  = (sync == SH_CTRL);
    assign hdr_bad = (sync != SH_CTRL) && (sync != SH_DATA);

    pcs_ctrl_decode dec_i (
        .payload  (payload),
        .type_ok  (d_type_ok),
        .code_bad (d_code_bad),
        .err_char (d_err_char),
        .sof      (d_sof),
        .sof_lane4(d_sof4),
        .term     (d_term),
        .term_pos (d_tpos),
        .oset     (d_oset),
        .oset_sig (d_osig),
        .oset_data(d_odata)
    );

    pcs_ber_fsm #(.WIN_BLOCKS(WIN_BLOCKS), .BER_THRESH(BER_THRESH)) ber_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_valid(in_valid),
        .hdr_bad  (hdr_bad),
        .hi_ber   (hi_ber)
    );

    assign e_type = is_ctl && !d_type_ok;
    assign e_code = is_ctl && d_type_ok && d_code_bad;
    assign e_char = is_ctl && d_type_ok && d_err_char;
    assign clean  = is_ctl && d_type_ok && !d_code_bad && !d_err_char;

    always_comb begin
        if (hdr_bad || e_type || e_code || e_char) kind = KIND_ERR;
        else if (is_ctl)                           kind = KIND_CTRL;
        else                                       kind = KIND_DATA;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid        <= 1'b0;
            out_kind         <= KIND_DATA;
            out_sof          <= 1'b0;
            out_sof_lane4    <= 1'b0;
            out_term         <= 1'b0;
            out_term_pos     <= 3'd0;
            out_oset         <= 1'b0;
            out_oset_sig     <= 1'b0;
            out_oset_data    <= 24'h0;
            out_local_fault  <= 1'b0;
            out_remote_fault <= 1'b0;
            out_err_char     <= 1'b0;
            out_err_hdr      <= 1'b0;
            out_err_type     <= 1'b0;
            out_err_code     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_kind         <= kind;
                out_sof          <= clean && d_sof;
                out_sof_lane4    <= clean && d_sof && d_sof4;
                out_term         <= clean && d_term;
                out_term_pos     <= (clean && d_term) ? d_tpos : 3'd0;
                out_oset         <= clean && d_oset;
                out_oset_sig     <= clean && d_oset && d_osig;
                out_oset_data    <= (clean && d_oset) ? d_odata : 24'h0;
                out_local_fault  <= clean && d_oset && !d_osig && d_odata == 24'h010000;
                out_remote_fault <= clean && d_oset && !d_osig && d_odata == 24'h020000;
                out_err_char     <= e_char;
                out_err_hdr      <= hdr_bad;
                out_err_type     <= e_type;
                out_err_code     <= e_code;
            end
        end
    end
endmodule

// File: rtl/pcs_blk_classifier_chk.sv
module pcs_blk_classifier_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [65:0] in_block,
    input logic        out_valid,
    input logic [1:0]  out_kind,
    input logic        out_sof,
    input logic        out_sof_lane4,
    input logic        out_term,
    input logic [2:0]  out_term_pos,
    input logic        out_oset,
    input logic        out_oset_sig,
    input logic [23:0] out_oset_data,
    input logic        out_local_fault,
    input logic        out_remote_fault,
    input logic        out_err_char,
    input logic        out_err_hdr,
    input logic        out_err_type,
    input logic        out_err_code,
    input logic        hi_ber
);
    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_hdr_err_from_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_block[1:0] == 2'b00 || in_block[1:0] == 2'b11)) |=> (out_err_hdr && out_kind == 2'd2));

    assert_causes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_err_hdr, out_err_type, out_err_code}));

    assert_flags_clean_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof || out_term || out_oset) |-> (out_kind == 2'd1));

    assert_char_errored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_err_char |-> (out_kind == 2'd2));

    assert_fault_is_sequence_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_local_fault || out_remote_fault) |-> (out_oset && !out_oset_sig));

    assert_sof_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof_lane4 |-> out_sof);

    assert_trip_on_bad_hdr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_ber) |-> $past(in_valid && (in_block[1:0] == 2'b00 || in_block[1:0] == 2'b11)));

    assert_clear_needs_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hi_ber) |-> $past(in_valid));
endmodule

bind pcs_blk_classifier pcs_blk_classifier_chk chk_i (.*);

// File: tb/pcs_blk_classifier_tb.sv
`timescale 1ns/1ps
module pcs_blk_classifier_tb_top;
    localparam int WIN = 8;
    localparam int THR = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [65:0] in_block = '0;
    logic        out_valid, out_sof, out_sof_lane4, out_term, out_oset, out_oset_sig;
    logic [1:0]  out_kind;
    logic [2:0]  out_term_pos;
    logic [23:0] out_oset_data;
    logic        out_local_fault, out_remote_fault, out_err_char;
    logic        out_err_hdr, out_err_type, out_err_code, hi_ber;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pcs_blk_classifier #(.WIN_BLOCKS(WIN), .BER_THRESH(THR)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_block(in_block),
        .out_valid(out_valid), .out_kind(out_kind), .out_sof(out_sof),
        .out_sof_lane4(out_sof_lane4), .out_term(out_term), .out_term_pos(out_term_pos),
        .out_oset(out_oset), .out_oset_sig(out_oset_sig), .out_oset_data(out_oset_data),
        .out_local_fault(out_local_fault), .out_remote_fault(out_remote_fault),
        .out_err_char(out_err_char), .out_err_hdr(out_err_hdr), .out_err_type(out_err_type),
        .out_err_code(out_err_code), .hi_ber(hi_ber)
    );

    // {kind, sof, lane4, term, pos, oset, sig, hdr, type, code, char}
    function automatic logic [14:0] obs();
        return {out_kind, out_sof, out_sof_lane4, out_term, out_term_pos, out_oset,
                out_oset_sig, out_err_hdr, out_err_type, out_err_code, out_err_char};
    endfunction

    function automatic logic [14:0] mk(input logic [1:0] k, input logic s, input logic s4,
                                       input logic t, input logic [2:0] tp, input logic o,
                                       input logic osig, input logic h, input logic ty,
                                       input logic c, input logic ch);
        return {k, s, s4, t, tp, o, osig, h, ty, c, ch};
    endfunction

    function automatic int term_idx(input logic [7:0] tf);
        logic [7:0] tl [8] = '{8'h87, 8'h99, 8'haa, 8'hb4, 8'hcc, 8'hd2, 8'he1, 8'hff};
        for (int i = 0; i < 8; i++) if (tl[i] == tf) return i;
        return -1;
    endfunction

    function automatic logic [14:0] exp_type(input logic [7:0] tf);
        logic legal;
        int   ti;
        ti = term_idx(tf);
        legal = (ti >= 0) || (tf inside {8'h1e, 8'h2d, 8'h33, 8'h4b, 8'h55, 8'h66, 8'h78});
        if (!legal) return mk(2'd2, 0, 0, 0, 3'd0, 0, 0, 0, 1, 0, 0);
        return mk(2'd1, tf inside {8'h78, 8'h33, 8'h66}, tf inside {8'h33, 8'h66},
                  ti >= 0, (ti >= 0) ? 3'(ti) : 3'd0,
                  tf inside {8'h2d, 8'h4b, 8'h55, 8'h66}, 0, 0, 0, 0, 0);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] sh, input logic [63:0] p);
        @(negedge clk);
        in_valid = 1'b1;
        in_block = {p, sh};
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R10: reset state
        check("R10 reset", {out_valid, obs(), out_oset_data, out_local_fault, out_remote_fault, hi_ber}, '0);

        // R10: one-cycle latency
        @(negedge clk);
        in_valid = 1'b1;
        in_block = {64'h0123456789abcdef, 2'b01};
        @(posedge clk);
        #1;
        check("R10 out_valid after one edge", {63'h0, out_valid}, 64'h1);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R10 out_valid drops", {63'h0, out_valid}, 64'h0);

        // R1: sync header sweep
        for (int s = 0; s < 4; s++) begin
            send(2'(s), 64'h0);
            if (s == 1)      check("R1 data header", 64'(obs()), 64'(mk(2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0)));
            else if (s == 2) check("R1 control header", 64'(obs()), 64'(mk(2'd2, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0)));
            else             check("R1 bad header", 64'(obs()), 64'(mk(2'd2, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0)));
        end

        // R2 R5 R6 R7: all type fields, rest zero
        for (int t = 0; t < 256; t++) begin
            send(2'b10, {56'h0, 8'(t)});
            check("R2/R5/R6/R7 type sweep", 64'(obs()), 64'(exp_type(8'(t))));
        end

        // R3 R4: all 7-bit codes in slot 0 of an all-control block
        for (int c = 0; c < 128; c++) begin
            logic legal;
            legal = 7'(c) inside {7'h00, 7'h1e, 7'h2d, 7'h33, 7'h4b, 7'h55, 7'h66, 7'h78};
            send(2'b10, {49'h0, 7'(c), 8'h1e});
            if (c == 'h1e)  check("R4 error char", 64'(obs()), 64'(mk(2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1)));
            else if (legal) check("R3 legal code", 64'(obs()), 64'(mk(2'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0)));
            else            check("R3 illegal code", 64'(obs()), 64'(mk(2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0)));
        end

        // R3: nonzero reserved bit in lane-4 start block
        send(2'b10, {24'h0, 4'h1, 28'h0, 8'h33});
        check("R3 reserved 0x33", 64'(obs()), 64'(mk(2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0)));
        // R3: nonzero reserved bit after terminate at position 0
        send(2'b10, {49'h0, 7'h01, 8'h87});
        check("R3 reserved 0x87", 64'(obs()), 64'(mk(2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0)));
        // R3: bad ordered-set code
        send(2'b10, {28'h0, 4'h3, 24'h0, 8'h4b});
        check("R3 bad oset code", 64'(obs()), 64'(mk(2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0)));
        // R4 R9: error char after terminate at position 0, term suppressed
        send(2'b10, {42'h0, 7'h1e, 7'h0, 8'h87});
        check("R4/R9 err char in term block", 64'(obs()), 64'(mk(2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1)));
        // R9: bad header wins over bad type
        send(2'b00, {56'h0, 8'h00});
        check("R9 header priority", 64'(obs()), 64'(mk(2'd2, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0)));

        // R7 R8: local fault at lane 0
        send(2'b10, {28'h0, 4'h0, 24'h010000, 8'h4b});
        check("R8 local fault", {61'h0, out_oset, out_local_fault, out_remote_fault}, 64'b110);
        check("R7 lane0 oset data", 64'(out_oset_data), 64'h010000);
        // R7 R8: remote fault at lane 4
        send(2'b10, {24'h020000, 4'h0, 28'h0, 8'h2d});
        check("R8 remote fault", {61'h0, out_oset, out_local_fault, out_remote_fault}, 64'b101);
        // R7: signal ordered set
        send(2'b10, {28'h0, 4'hf, 24'h4a4a95, 8'h4b});
        check("R7 signal oset", {38'h0, out_oset, out_oset_sig, out_oset_data}, {38'h0, 2'b11, 24'h4a4a95});
        check("R8 no fault on signal", {62'h0, out_local_fault, out_remote_fault}, 64'h0);
        // R7: 0x55 reports lane-0 set
        send(2'b10, {24'h070605, 4'h0, 4'hf, 24'h030201, 8'h55});
        check("R7 0x55 oset", {39'h0, out_oset_sig, out_oset_data}, {39'h0, 1'b1, 24'h030201});

        // R11 R12: rate monitor, window 8, threshold 3
        do_reset();
        check("R11 clear after reset", {63'h0, hi_ber}, 64'h0);
        send(2'b00, 64'h0);
        send(2'b11, 64'h0);
        for (int i = 0; i < 5; i++) send(2'b01, 64'h0);
        check("R11 below threshold", {63'h0, hi_ber}, 64'h0);
        send(2'b01, 64'h0);
        check("R12 quiet window end", {63'h0, hi_ber}, 64'h0);
        send(2'b00, 64'h0);
        send(2'b00, 64'h0);
        check("R11 two errors", {63'h0, hi_ber}, 64'h0);
        send(2'b11, 64'h0);
        check("R11 trip on third", {63'h0, hi_ber}, 64'h1);
        for (int i = 0; i < 5; i++) send(2'b01, 64'h0);
        check("R12 hold at busy window end", {63'h0, hi_ber}, 64'h1);
        for (int i = 0; i < 7; i++) send(2'b01, 64'h0);
        check("R12 hold before window end", {63'h0, hi_ber}, 64'h1);
        send(2'b01, 64'h0);
        check("R12 clear at quiet window end", {63'h0, hi_ber}, 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule